// File: doc/BRIEF.md
# Byte-Masked Single-Port RAM with Selectable Read-During-Write

This block is a synchronous single-port memory. It has one clock, one address, a write word, a write enable, a read enable and a write mask with one bit per byte. Every access happens on the rising clock edge. The read result goes into a registered output that loads only on read cycles.

A read and a write can reach the same address in the same cycle. A build-time parameter then sets what the read register captures. In new-data mode, every byte lane whose mask bit is set passes the incoming byte through to the output. A lane whose mask bit is clear is not written, so it shows its stored byte, and one output word can therefore mix new and old bytes. In old-data mode, every lane shows the word as it was before the write.

Top module: `bytemask_spram`

## Requirements
- R1: While rst_ni is low, rdata_o is all zeros.
- R2: rdata_o loads only on a rising edge where re_i is high; otherwise it keeps its previous value.
- R3: On a rising edge with we_i high, memory byte lane i at addr_i takes wdata_i[8i+7:8i] exactly when be_i[i] is 1, in both modes.
- R4: A read with we_i low puts the stored word at addr_i into rdata_o after the edge, in both modes.
- R5: In new-data mode (RDW_MODE = RDW_NEW), a read with we_i high makes each lane whose be_i bit is 1 show the byte written in that cycle.
- R6: In new-data mode, a read with we_i high makes each lane whose be_i bit is 0 show its stored byte, which is unchanged.
- R7: In old-data mode (RDW_MODE = RDW_OLD), a read with we_i high shows, in every lane, the word stored at addr_i before that edge.
- R8: A write with be_i all zeros leaves the memory word unchanged.
- R9: Bit i of be_i governs only bits [8i+7:8i] of the data word. Lanes are independent: alternating masks such as 0101 and 1010 touch only the flagged lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all accesses occur on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the read register |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| be_i | input | DATA_W/8 | Per-byte write mask, bit i for bits [8i+7:8i] |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The assertions check on every cycle that the read register holds while reads are idle. They also check that a flagged lane stores its byte and an unflagged lane keeps its byte. Finally, they check that a same-cycle read shows the new byte or the prior byte in each lane, according to the mode.

Some behaviour only the bench scenarios can show: mixed words after alternating masks, data surviving back-to-back writes to one address, and writes with every lane masked. The bench shows these by comparing reads in both modes against a reference memory.

// File: rtl/spram_pkg.sv
package spram_pkg;
  typedef enum logic {RDW_OLD = 1'b0, RDW_NEW = 1'b1} rdw_mode_e;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/spram_lane.sv
module spram_lane #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wbyte_i,
  output logic [7:0]        rbyte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wbyte_i;
  end

  assign rbyte_o = mem_q[addr_i];

  // R3: flagged lane lands the byte
  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[$past(addr_i)] == $past(wbyte_i));
  // R8: unflagged lane keeps its byte
  p_masked_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> mem_q[$past(addr_i)] == $past(rbyte_o));
endmodule

// File: rtl/spram_rdw_sel.sv
module spram_rdw_sel
  import spram_pkg::*;
#(
  parameter rdw_mode_e   RDW_MODE = RDW_NEW,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned NB      = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] stored_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NB-1:0]     wmask_i,
  output logic [DATA_W-1:0] next_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    if (RDW_MODE == RDW_NEW) begin : g_new
      assign next_o[i*LANE_W +: LANE_W] = wmask_i[i] ? wdata_i[i*LANE_W +: LANE_W]
                                                     : stored_i[i*LANE_W +: LANE_W];
    end else begin : g_old
      assign next_o[i*LANE_W +: LANE_W] = stored_i[i*LANE_W +: LANE_W];
    end
  end

  if (RDW_MODE == RDW_OLD) begin : g_unused
    logic unused_w;
    assign unused_w = ^{wdata_i, wmask_i};
  end
endmodule

// File: rtl/spram_out_reg.sv
module spram_out_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/bytemask_spram.sv
module bytemask_spram
  import spram_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 64,
  parameter rdw_mode_e   RDW_MODE = RDW_NEW,
  localparam int unsigned ADDR_W  = $clog2(DEPTH),
  localparam int unsigned NB      = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [NB-1:0]     be_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NB-1:0]     wmask;
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] rd_next;

  assign wmask = be_i & {NB{we_i}};

  for (genvar i = 0; i < NB; i++) begin : g_bank
    spram_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (addr_i),
      .wr_i   (wmask[i]),
      .wbyte_i(wdata_i[i*LANE_W +: LANE_W]),
      .rbyte_o(stored[i*LANE_W +: LANE_W])
    );
  end

  spram_rdw_sel #(.RDW_MODE(RDW_MODE), .DATA_W(DATA_W)) u_sel (
    .stored_i(stored),
    .wdata_i (wdata_i),
    .wmask_i (wmask),
    .next_o  (rd_next)
  );

  spram_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (re_i),
    .d_i   (rd_next),
    .q_o   (rdata_o)
  );

  // R1: reset clears the read register
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_zero_r1: assert (rdata_o == '0);
  end

  for (genvar i = 0; i < NB; i++) begin : g_chk
    if (RDW_MODE == RDW_NEW) begin : g_new
      p_pass_new_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && we_i && be_i[i]) |=>
          rdata_o[i*LANE_W +: LANE_W] == $past(wdata_i[i*LANE_W +: LANE_W]));
      p_masked_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && we_i && !be_i[i]) |=>
          rdata_o[i*LANE_W +: LANE_W] == $past(stored[i*LANE_W +: LANE_W]));
    end else begin : g_old
      p_prior_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && we_i) |=>
          rdata_o[i*LANE_W +: LANE_W] == $past(stored[i*LANE_W +: LANE_W]));
    end
  end
endmodule

// File: tb/tb_bytemask_spram.sv
`timescale 1ns/1ps
module tb_bytemask_spram;
  import spram_pkg::*;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEPTH  = 64;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned NB     = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [NB-1:0] be = '0;
  logic [DATA_W-1:0] q_new, q_old;

  int total = 0, bad = 0;
  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [DATA_W-1:0] exp_new = '0, exp_old = '0;

  always #10 clk = ~clk;

  bytemask_spram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RDW_MODE(RDW_NEW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .be_i(be), .rdata_o(q_new));
  bytemask_spram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RDW_MODE(RDW_OLD)) dut_old (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .be_i(be), .rdata_o(q_old));

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
      input logic [DATA_W-1:0] new_w, input logic [NB-1:0] m);
    logic [DATA_W-1:0] r = old_w;
    for (int i = 0; i < NB; i++) if (m[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, clock edge in between, check at next negedge
  task automatic access(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic w, input logic r, input logic [NB-1:0] m);
    logic [DATA_W-1:0] prior;
    string tag;
    addr = a; wdata = d; we = w; re = r; be = m;
    prior = ref_mem[a];
    if (r) begin
      exp_old = prior;
      exp_new = w ? merge(prior, d, m) : prior;
    end
    if (w) ref_mem[a] = merge(prior, d, m);
    @(negedge clk);
    if (!r) tag = "R2 hold";
    else if (!w) tag = "R4 plain read";
    else tag = "R5 R6 R9 rdw";
    check({tag, " new-mode"}, q_new, exp_new);
    if (r && w) tag = "R7 rdw";
    check({tag, " old-mode"}, q_old, exp_old);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk); @(negedge clk);
    check("R1 reset new", q_new, '0);
    check("R1 reset old", q_old, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R3: fill every word with a full mask, no read
    for (int a = 0; a < DEPTH; a++) access(a[ADDR_W-1:0], {4{a[7:0]}} ^ 32'hA5C3_0F81, 1'b1, 1'b0, '1);
    // R4: read back
    for (int a = 0; a < 8; a++) access(a[ADDR_W-1:0], '0, 1'b0, 1'b1, '0);
    // back-to-back writes to one address with reads (R5 R6 R7)
    access(6'd5, 32'h1111_1111, 1'b1, 1'b1, 4'b1111);
    access(6'd5, 32'h2222_2222, 1'b1, 1'b1, 4'b0011);
    access(6'd5, 32'h3333_3333, 1'b1, 1'b1, 4'b1100);
    access(6'd5, 32'h0, 1'b0, 1'b1, 4'b0);
    // R8: all lanes masked
    access(6'd9, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'b0000);
    access(6'd9, 32'h0, 1'b0, 1'b1, 4'b0);
    // R9: alternating masks
    access(6'd12, 32'hAAAA_AAAA, 1'b1, 1'b1, 4'b0101);
    access(6'd12, 32'h5555_5555, 1'b1, 1'b1, 4'b1010);
    access(6'd12, 32'hCCCC_CCCC, 1'b1, 1'b0, 4'b0101);
    access(6'd12, 32'h0, 1'b0, 1'b1, 4'b0);
    // R2: write without read leaves output held
    access(6'd20, 32'h7777_7777, 1'b1, 1'b0, 4'b1111);
    // random mix
    for (int n = 0; n < 3000; n++)
      access($urandom_range(DEPTH-1), $urandom, $urandom_range(1), $urandom_range(1),
             $urandom_range((1 << NB) - 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule